// File: doc/BRIEF.md
# SDRAM Refresh Scheduler

This block lives inside an SDRAM controller and owns every refresh-related command the memory receives. An interval timer derived from the clock rate marks each point where one auto-refresh falls due (4096 refreshes per 64 ms, about one every 15.6 µs). Refreshes that fall due are added to an owed count. While anything is owed, the scheduler asks an arbiter for the command bus. Once the arbiter grants the bus, the scheduler closes any open banks with a precharge-all. It then issues the owed refreshes back to back, spaced by the row cycle time, and releases the bus.

When the rest of the controller is idle, it can raise a level request to put the memory into self refresh. The scheduler enters self refresh by issuing the refresh pattern with the clock enable falling. It holds the clock enable low for as long as the request stays high. When the request drops, it raises the clock enable with a no-operation, waits one row cycle, and hands the bus back. All command pins are registered.

Top module: `sdram_refresh_sched`

## Requirements
- R1: After reset, bus_req_o is 0, cmd_cs_n_o is 1 (deselect), cmd_cke_o is 1, owed_o is 0 and overflow_o is 0.
- R2: One refresh falls due every REFI_CYC = REFI_NS*CLK_MHZ/1000 clock cycles counted from reset release. Each one adds 1 to owed_o, except while the memory is in self refresh.
- R3: bus_req_o rises while a refresh is owed or self refresh is requested. No command (cmd_cs_n_o low) is driven unless bus_gnt_i has been seen high during the current request. The encodings {cs_n,ras_n,cas_n,we_n} are: refresh 0001, precharge 0010, no-operation 0111, deselect cs_n=1.
- R4: If bank_open_i is high when the grant is taken, a precharge-all (pattern 0010 with cmd_a10_o=1) is issued first. The next command (refresh or self-refresh entry) follows exactly TRP_CYC cycles later. If bank_open_i is low, no precharge is issued.
- R5: After each refresh only no-operations are driven. No refresh or self-refresh entry follows sooner than TRC_CYC cycles after it.
- R6: Each refresh lowers owed_o by one. Owed refreshes are issued within one bus tenure at exactly TRC_CYC spacing. When the bus is released, owed_o is 0 unless a new refresh fell due on that very cycle.
- R7: owed_o saturates at MAX_OWED (8). A refresh falling due while 8 are owed sets overflow_o, which stays set until reset.
- R8: Self-refresh entry is the refresh pattern with cmd_cke_o going 1→0. It is issued only when owed_o was 0 in the cycle before. cmd_cke_o stays 0 with cmd_cs_n_o=1 while sr_req_i stays high.
- R9: When sr_req_i falls during self refresh, cmd_cke_o rises together with a no-operation. bus_req_o falls exactly TRC_CYC cycles after that rise.
- R10: Whenever bus_req_o falls, the pins are at deselect with cmd_cke_o=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_open_i | input | 1 | High when at least one bank holds an open row |
| sr_req_i | input | 1 | Level request to stay in self refresh |
| bus_gnt_i | input | 1 | Command-bus grant from the arbiter |
| bus_req_o | output | 1 | Command-bus request to the arbiter |
| cmd_cs_n_o | output | 1 | Chip select, active low |
| cmd_ras_n_o | output | 1 | Row strobe, active low |
| cmd_cas_n_o | output | 1 | Column strobe, active low |
| cmd_we_n_o | output | 1 | Write enable, active low |
| cmd_a10_o | output | 1 | Address bit 10 (all-bank select for precharge) |
| cmd_cke_o | output | 1 | Clock enable |
| owed_o | output | $clog2(MAX_OWED+1) | Number of refreshes currently owed |
| overflow_o | output | 1 | Sticky flag: a refresh was lost at saturation |

## Verification
A wrong owed count shows at the ports within one refresh interval. It appears as owed_o off by one, as a bus request that never drops, or as a tenure with the wrong number of refresh commands. A wait counter loaded with the wrong value shows on the first precharge or refresh of a tenure, as a command gap other than TRP_CYC or TRC_CYC. A wrong state after self refresh shows within a few cycles. It appears as a clock-enable edge with the wrong pin pattern, or as a bus release at a distance from the exit other than TRC_CYC.

// File: rtl/sdram_rfsh_pkg.sv
package sdram_rfsh_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_REQ,
        ST_PRE,
        ST_WAIT_RP,
        ST_REF,
        ST_WAIT_RC,
        ST_SRE,
        ST_SELF,
        ST_SRX,
        ST_WAIT_SRX
    } rf_state_t;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic a10;
        logic cke;
    } rf_pins_t;

    // Pin pattern held while the scheduler is in a given state.
    function automatic rf_pins_t pins_for(rf_state_t s);
        rf_pins_t p;
        p = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, a10: 1'b0, cke: 1'b1};
        case (s)
            ST_PRE:      p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0, a10: 1'b1, cke: 1'b1};
            ST_REF:      p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1, a10: 1'b0, cke: 1'b1};
            ST_SRE:      p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1, a10: 1'b0, cke: 1'b0};
            ST_SELF:     p = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, a10: 1'b0, cke: 1'b0};
            ST_WAIT_RP,
            ST_WAIT_RC,
            ST_SRX,
            ST_WAIT_SRX: p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, a10: 1'b0, cke: 1'b1};
            default:     p = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, a10: 1'b0, cke: 1'b1};
        endcase
        return p;
    endfunction

endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
    parameter int PERIOD = 1953
) (
    input  logic clk,
    input  logic rst_n,
    output logic due_o
);
    localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(PERIOD - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (cnt_q == '0) cnt_d = RELOAD;
        else             cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= RELOAD;
        else        cnt_q <= cnt_d;
    end

    assign due_o = (cnt_q == '0);

    generate
        if (PERIOD > 1) begin : g_chk
            AST_DUE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
                due_o |=> !due_o); // R2
        end
    endgenerate

endmodule

// File: rtl/rfsh_owed_counter.sv
module rfsh_owed_counter #(
    parameter int MAX_OWED = 8,
    localparam int OW = $clog2(MAX_OWED + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          due_i,
    input  logic          count_en_i,
    input  logic          issued_i,
    input  logic          clear_i,
    output logic [OW-1:0] owed_o,
    output logic          overflow_o
);
    localparam logic [OW-1:0] LIMIT = OW'(MAX_OWED);

    typedef struct packed {
        logic [OW-1:0] owed;
        logic          ovf;
    } oc_t;

    oc_t cur_q, nxt_d;
    logic add;

    always_comb begin
        nxt_d = cur_q;
        add   = due_i && count_en_i;
        if (clear_i) begin
            nxt_d.owed = '0;
        end else begin
            case ({add, issued_i})
                2'b10: begin
                    if (cur_q.owed == LIMIT) nxt_d.ovf  = 1'b1;
                    else                     nxt_d.owed = cur_q.owed + 1'b1;
                end
                2'b01: begin
                    if (cur_q.owed != '0)    nxt_d.owed = cur_q.owed - 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign owed_o     = cur_q.owed;
    assign overflow_o = cur_q.ovf;

    AST_OWED_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.owed <= LIMIT); // R7
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |=> overflow_o); // R7
    AST_ISSUE_NEEDS_OWED: assert property (@(posedge clk) disable iff (!rst_n)
        issued_i |-> (owed_o != '0)); // R6

endmodule

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched
    import sdram_rfsh_pkg::*;
#(
    parameter int CLK_MHZ  = 125,
    parameter int REFI_NS  = 15625,
    parameter int TRP_CYC  = 3,
    parameter int TRC_CYC  = 9,
    parameter int MAX_OWED = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bank_open_i,
    input  logic                          sr_req_i,
    input  logic                          bus_gnt_i,
    output logic                          bus_req_o,
    output logic                          cmd_cs_n_o,
    output logic                          cmd_ras_n_o,
    output logic                          cmd_cas_n_o,
    output logic                          cmd_we_n_o,
    output logic                          cmd_a10_o,
    output logic                          cmd_cke_o,
    output logic [$clog2(MAX_OWED+1)-1:0] owed_o,
    output logic                          overflow_o
);
    localparam int REFI_CYC = (REFI_NS * CLK_MHZ) / 1000;
    localparam int OW       = $clog2(MAX_OWED + 1);
    localparam int WMAX     = (TRC_CYC > TRP_CYC) ? TRC_CYC : TRP_CYC;
    localparam int WW       = $clog2(WMAX + 1);
    localparam logic [WW-1:0] RP_LOAD = WW'(TRP_CYC - 2);
    localparam logic [WW-1:0] RC_LOAD = WW'(TRC_CYC - 2);

    typedef struct packed {
        rf_state_t     state;
        logic [WW-1:0] wait_cnt;
        rf_pins_t      pins;
    } sched_t;

    sched_t cur_q, nxt_d;

    logic          due;
    logic [OW-1:0] owed;
    logic          ovf;
    logic          owes;
    logic          ref_issued;
    logic          in_sr;
    logic          sr_clear;

    rfsh_interval_timer #(.PERIOD(REFI_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .due_o (due)
    );

    assign ref_issued = (cur_q.state == ST_REF);
    assign in_sr      = (cur_q.state == ST_SRE) || (cur_q.state == ST_SELF);
    assign sr_clear   = (cur_q.state == ST_SRE);

    rfsh_owed_counter #(.MAX_OWED(MAX_OWED)) u_owed (
        .clk        (clk),
        .rst_n      (rst_n),
        .due_i      (due),
        .count_en_i (!in_sr),
        .issued_i   (ref_issued),
        .clear_i    (sr_clear),
        .owed_o     (owed),
        .overflow_o (ovf)
    );

    assign owes = (owed != '0);

    always_comb begin
        nxt_d = cur_q;
        case (cur_q.state)
            ST_IDLE: begin
                if (owes || sr_req_i) nxt_d.state = ST_REQ;
            end
            ST_REQ: begin
                if (bus_gnt_i) begin
                    if (bank_open_i)   nxt_d.state = ST_PRE;
                    else if (owes)     nxt_d.state = ST_REF;
                    else if (sr_req_i) nxt_d.state = ST_SRE;
                    else               nxt_d.state = ST_IDLE;
                end
            end
            ST_PRE: begin
                nxt_d.state    = ST_WAIT_RP;
                nxt_d.wait_cnt = RP_LOAD;
            end
            ST_WAIT_RP: begin
                if (cur_q.wait_cnt != '0) begin
                    nxt_d.wait_cnt = cur_q.wait_cnt - 1'b1;
                end else if (owes) begin
                    nxt_d.state = ST_REF;
                end else if (sr_req_i) begin
                    nxt_d.state = ST_SRE;
                end else begin
                    nxt_d.state = ST_IDLE;
                end
            end
            ST_REF: begin
                nxt_d.state    = ST_WAIT_RC;
                nxt_d.wait_cnt = RC_LOAD;
            end
            ST_WAIT_RC: begin
                if (cur_q.wait_cnt != '0) begin
                    nxt_d.wait_cnt = cur_q.wait_cnt - 1'b1;
                end else if (owes) begin
                    nxt_d.state = ST_REF;
                end else if (sr_req_i) begin
                    nxt_d.state = ST_SRE;
                end else begin
                    nxt_d.state = ST_IDLE;
                end
            end
            ST_SRE: begin
                nxt_d.state = ST_SELF;
            end
            ST_SELF: begin
                if (!sr_req_i) nxt_d.state = ST_SRX;
            end
            ST_SRX: begin
                nxt_d.state    = ST_WAIT_SRX;
                nxt_d.wait_cnt = RC_LOAD;
            end
            ST_WAIT_SRX: begin
                if (cur_q.wait_cnt != '0) nxt_d.wait_cnt = cur_q.wait_cnt - 1'b1;
                else                      nxt_d.state    = ST_IDLE;
            end
            default: nxt_d.state = ST_IDLE;
        endcase
        nxt_d.pins = pins_for(nxt_d.state);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.state    <= ST_IDLE;
            cur_q.wait_cnt <= '0;
            cur_q.pins     <= pins_for(ST_IDLE);
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign bus_req_o   = (cur_q.state != ST_IDLE);
    assign cmd_cs_n_o  = cur_q.pins.cs_n;
    assign cmd_ras_n_o = cur_q.pins.ras_n;
    assign cmd_cas_n_o = cur_q.pins.cas_n;
    assign cmd_we_n_o  = cur_q.pins.we_n;
    assign cmd_a10_o   = cur_q.pins.a10;
    assign cmd_cke_o   = cur_q.pins.cke;
    assign owed_o      = owed;
    assign overflow_o  = ovf;

    AST_CMD_NEEDS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_cs_n_o |-> bus_req_o); // R3
    AST_GRANT_BEFORE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_q.state == ST_REQ) && !bus_gnt_i) |=> cmd_cs_n_o); // R3
    AST_PREA_ALL_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_cs_n_o && !cmd_ras_n_o && cmd_cas_n_o && !cmd_we_n_o) |-> cmd_a10_o); // R4
    AST_WAIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.wait_cnt <= WW'(WMAX)); // R5
    AST_CKE_FALL_IS_SRE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_cke_o) |-> (!cmd_cs_n_o && !cmd_ras_n_o && !cmd_cas_n_o && cmd_we_n_o)); // R8
    AST_CKE_RISE_IS_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_cke_o) |-> (!cmd_cs_n_o && cmd_ras_n_o && cmd_cas_n_o && cmd_we_n_o)); // R9
    AST_RELEASE_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_req_o) |-> (cmd_cs_n_o && cmd_cke_o)); // R10

endmodule

// File: tb/tb_sdram_refresh_sched.sv
module tb_sdram_refresh_sched;
    localparam int CLK_MHZ = 125;
    localparam int REFI_NS = 400;
    localparam int REFI    = REFI_NS * CLK_MHZ / 1000;   // 50 cycles
    localparam int TRP     = 3;
    localparam int TRC     = 6;
    localparam int MAXO    = 8;
    localparam int WD_LIM  = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bank_open = 1'b0;
    logic sr_req = 1'b0;
    logic gnt = 1'b0;
    logic bus_req, cs_n, ras_n, cas_n, we_n, a10, cke, ovf;
    logic [3:0] owed;

    always #4 clk = ~clk;

    sdram_refresh_sched #(
        .CLK_MHZ(CLK_MHZ), .REFI_NS(REFI_NS), .TRP_CYC(TRP), .TRC_CYC(TRC), .MAX_OWED(MAXO)
    ) dut (
        .clk(clk), .rst_n(rst_n), .bank_open_i(bank_open), .sr_req_i(sr_req),
        .bus_gnt_i(gnt), .bus_req_o(bus_req),
        .cmd_cs_n_o(cs_n), .cmd_ras_n_o(ras_n), .cmd_cas_n_o(cas_n), .cmd_we_n_o(we_n),
        .cmd_a10_o(a10), .cmd_cke_o(cke), .owed_o(owed), .overflow_o(ovf)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;
    bit arb_en = 1'b0;
    int n_refa = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    function automatic bit is_nop(logic c, logic r, logic ca, logic w);
        return !c && r && ca && w;
    endfunction

    function automatic bit is_refpat(logic c, logic r, logic ca, logic w);
        return !c && !r && !ca && w;
    endfunction

    function automatic bit is_prepat(logic c, logic r, logic ca, logic w);
        return !c && !r && ca && !w;
    endfunction

    always @(posedge clk) begin
        if (rst_n) cyc <= cyc + 1;
        if (cyc > WD_LIM) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, WD_LIM);
            finish_run();
        end
    end

    // Arbiter model: grants after a random delay, withdraws with the request.
    initial begin
        int dly = 0;
        forever begin
            @(negedge clk);
            if (!arb_en || !bus_req) begin
                gnt = 1'b0;
                dly = $urandom_range(0, 4);
            end else if (!gnt) begin
                if (dly == 0) gnt = 1'b1;
                else dly--;
            end
        end
    end

    // Pin monitor: checks command ordering and spacing against the requirements.
    initial begin
        logic p_cke = 1'b1, p_req = 1'b0, p_sr = 1'b0;
        int   p_owed = 0;
        bit   gnt_seen = 0, pre_exp = 0, pre_done = 0;
        int   last_kind = 0;  // 0 none, 1 precharge, 2 refresh, 3 sr entry, 4 sr exit
        int   last_t = 0;
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            if (bus_req && gnt && !gnt_seen) begin
                gnt_seen = 1;
                pre_exp  = bank_open;
                pre_done = 0;
            end
            if (p_cke && !cke) begin
                check(is_refpat(cs_n, ras_n, cas_n, we_n), "R8", "entry pattern is refresh", cs_n, 0);
                check(p_owed == 0, "R8", "owed before entry", p_owed, 0);
                if (last_kind == 1) check(cyc - last_t == TRP, "R4", "precharge to sr entry gap", cyc - last_t, TRP);
                else check(!pre_exp || pre_done, "R4", "precharge before sr entry", pre_done, 1);
                if (last_kind == 2) check(cyc - last_t >= TRC, "R5", "refresh to sr entry gap", cyc - last_t, TRC);
                last_kind = 3; last_t = cyc;
            end else if (!p_cke && !cke) begin
                if (!cs_n) check(0, "R8", "pins deselected in self refresh", cs_n, 1);
            end else if (!p_cke && cke) begin
                check(is_nop(cs_n, ras_n, cas_n, we_n), "R9", "exit is nop", ras_n, 1);
                check(!p_sr, "R9", "exit follows request drop", p_sr, 0);
                last_kind = 4; last_t = cyc;
            end else if (!cs_n) begin
                if (!gnt_seen) check(0, "R3", "command without grant", cs_n, 1);
                if (is_refpat(cs_n, ras_n, cas_n, we_n)) begin
                    n_refa++;
                    if (last_kind == 1) check(cyc - last_t == TRP, "R4", "precharge to refresh gap", cyc - last_t, TRP);
                    else check(!pre_exp || pre_done, "R4", "precharge before refresh", pre_done, 1);
                    if (last_kind == 2) check(cyc - last_t == TRC, "R6", "chained refresh spacing", cyc - last_t, TRC);
                    last_kind = 2; last_t = cyc;
                end else if (is_prepat(cs_n, ras_n, cas_n, we_n)) begin
                    check(a10 == 1'b1, "R4", "precharge all banks a10", a10, 1);
                    check(pre_exp && !pre_done, "R4", "precharge only when banks open", pre_exp, 1);
                    pre_done = 1;
                    last_kind = 1; last_t = cyc;
                end else if (!is_nop(cs_n, ras_n, cas_n, we_n)) begin
                    check(0, "R5", "unexpected command", {ras_n, cas_n, we_n}, 7);
                end
            end
            if (p_req && !bus_req) begin
                check(cs_n && cke, "R10", "deselect at release", {cs_n, cke}, 3);
                if (last_kind == 4) check(cyc - last_t == TRC, "R9", "exit to release gap", cyc - last_t, TRC);
                gnt_seen = 0; pre_done = 0; last_kind = 0;
            end
            p_cke = cke; p_req = bus_req; p_sr = sr_req; p_owed = int'(owed);
        end
    end

    task automatic wait_to(input int c);
        do @(negedge clk); while (cyc < c);
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (bus_req);
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        check(!bus_req && cs_n && cke && owed == 0 && !ovf, "R1", "reset outputs",
              {bus_req, cs_n, cke, ovf}, 4'b0110);
        rst_n = 1'b1;
        @(negedge clk);
        check(!bus_req && cs_n && cke && owed == 0 && !ovf, "R1", "after release",
              {bus_req, cs_n, cke, ovf}, 4'b0110);

        // Grant withheld: owed accumulates at the interval rate.
        for (int k = 1; k <= 3; k++) begin
            wait_to(k * REFI + REFI / 2);
            check(owed == 4'(k), "R2", "owed after intervals", owed, k);
        end
        check(bus_req && cs_n, "R3", "request raised, no command yet", {bus_req, cs_n}, 3);
        wait_to(8 * REFI + REFI / 2);
        check(owed == 4'(MAXO) && !ovf, "R7", "saturated without overflow", owed, MAXO);
        wait_to(9 * REFI + REFI / 2);
        check(owed == 4'(MAXO) && ovf, "R7", "overflow after extra due", {ovf, owed}, 16 + MAXO);

        // Release the grant: owed refreshes drain in one tenure.
        n_refa = 0;
        arb_en = 1'b1;
        wait_idle();
        check(n_refa >= MAXO, "R6", "refreshes issued in tenure", n_refa, MAXO);
        check(int'(owed) == ((cyc % REFI == 0) ? 1 : 0), "R6", "owed at release",
              owed, (cyc % REFI == 0) ? 1 : 0);

        // Directed: open banks with a plain refresh.
        bank_open = 1'b1;
        do @(negedge clk); while (!bus_req);
        wait_idle();
        bank_open = 1'b0;

        // Random mix of open banks, self-refresh visits and idle gaps.
        for (int it = 0; it < 40; it++) begin
            wait_idle();
            bank_open = $urandom_range(0, 1);
            if ($urandom_range(0, 2) == 0) begin
                sr_req = 1'b1;
                do @(negedge clk); while (cke);
                repeat ($urandom_range(5, 40)) begin
                    @(negedge clk);
                    if (cke) check(0, "R8", "cke held low", cke, 0);
                end
                sr_req = 1'b0;
                do @(negedge clk); while (!cke);
                bank_open = 1'b0;
                wait_idle();
            end else begin
                repeat ($urandom_range(10, 80)) @(negedge clk);
                bank_open = 1'b0;
            end
        end
        wait_idle();
        check(ovf == 1'b1, "R7", "overflow still set", ovf, 1);
        finish_run();
    end

endmodule